// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a free-running timer. The up-counter and its one-cycle overflow strobe are shared and live outside the block. A mode input splits the channel into two uses. In capture use it watches an input pin through a two-stage synchroniser. On the selected edge it stores the counter value and raises a sticky flag, which software clears with a one-cycle strobe. In compare use it drives the pin itself. When the counter equals a compare value it sets, clears or toggles the pin. It can also toggle the pin at every counter overflow, which turns the channel into a pulse-width modulator.

A two-bit edge/level field selects the capture edge or the compare action. When that field is zero, the channel lets go of the pin. The overflow-toggle action takes priority over a compare action that falls in the same cycle. A maximum-duty input forces the modulator output to its 100% level, which is a steady high in the clear-on-match configuration. The block samples this input only at counter overflows, so forcing starts and stops on period boundaries.

Control is a four-state machine:
- `ST_OFF`: the pin is released.
- `ST_CAP`: the channel is listening for edges.
- `ST_LOW`: the channel drives a low level.
- `ST_HIGH`: the channel drives a high level.

Transitions:
- Any state goes to `ST_OFF` when the field is zero.
- Any state goes to `ST_CAP` when capture mode is selected with a non-zero field.
- `ST_OFF` or `ST_CAP` enters `ST_LOW` when compare mode is chosen.
- Between `ST_LOW` and `ST_HIGH`, the machine moves on an overflow toggle or on a compare action.

Top module: `tmr_chan`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pin_oe_o, pin_o and flag_o are 0 and cap_val_o is all zeros. Reset also clears the forced-duty state.
- R2: One cycle after edge_sel_i is 2'b00, pin_oe_o and pin_o are 0 and no capture occurs.
- R3: In capture mode (cap_mode_i = 1), edge_sel_i selects the capture edge: 01 = rising, 10 = falling, 11 = either. A level change of pin_i that is present at clock edge k is captured at edge k+2. The captured value is the counter value cnt_i present just before edge k+2.
- R4: Each capture loads cap_val_o and sets flag_o in the same clock edge. Outside a capture, cap_val_o holds its value. A flag_clr_i pulse clears flag_o at the next edge, and a capture in that same cycle wins over the clear.
- R5: In compare mode, the channel starts driving low one cycle after it is entered. When cnt_i equals cmp_val_i, edge_sel_i selects the action taken at the next edge: 01 = toggle, 10 = drive low, 11 = drive high.
- R6: With tog_ovf_i = 1 in compare mode, each ovf_i cycle toggles the pin level. With tog_ovf_i = 0 the overflow is ignored. In capture mode tog_ovf_i has no effect.
- R7: With tog_ovf_i = 1, an overflow and a compare match in the same cycle produce only the overflow toggle.
- R8: In the clear-on-match modulator configuration (compare mode, tog_ovf_i = 1, edge_sel_i = 10), max_duty_i is sampled at each ovf_i cycle. A sample of 1 forces pin_o high for the whole following period. A sample of 0 restores normal output from the following period.
- R9: max_duty_i does not affect pin_o in any configuration other than the one named in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_i | input | CNT_W | Shared timer count |
| ovf_i | input | 1 | One-cycle counter overflow strobe |
| cap_mode_i | input | 1 | 1 = capture use, 0 = compare use |
| edge_sel_i | input | 2 | Edge/level select; 00 releases the pin |
| tog_ovf_i | input | 1 | Toggle the pin on each overflow |
| max_duty_i | input | 1 | Request 100% modulator duty |
| cmp_val_i | input | CNT_W | Compare value |
| pin_i | input | 1 | Asynchronous pin level |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| cap_val_o | output | CNT_W | Captured count |
| flag_o | output | 1 | Capture flag |
| pin_o | output | 1 | Driven pin level |
| pin_oe_o | output | 1 | Pin drive enable |

## Verification
The assertions assume two things about the inputs. First, ovf_i is a single-cycle pulse. Second, the configuration inputs are held steady for at least one cycle around the overflow and compare events they judge. The overflow and forcing properties therefore hold only when the next cycle still shows the same configuration. The stimulus changes configuration only between phases and keeps ovf_i tied to the counter wrap, so every overflow is a lone pulse. The pin moves only at falling clock edges, and its gaps are long enough that the synchroniser never sees two changes closer than one cycle.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_CAP  = 2'b01,
        ST_LOW  = 2'b10,
        ST_HIGH = 2'b11
    } ch_state_t;

    // edge/level codes: capture meaning / compare meaning
    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_A    = 2'b01; // rising / toggle
    localparam logic [1:0] SEL_B    = 2'b10; // falling / clear
    localparam logic [1:0] SEL_C    = 2'b11; // both / set

endpackage

// File: rtl/tmr_chan_edge.sv
module tmr_chan_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[LAST-1:0], pin_i};
    end

    assign rise_o =  sh_q[LAST-1] & ~sh_q[LAST];
    assign fall_o = ~sh_q[LAST-1] &  sh_q[LAST];
endmodule

// File: rtl/tmr_chan_capture.sv
module tmr_chan_capture
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             listen_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             flag_clr_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             flag_o
);
    always_comb begin
        unique case (edge_sel_i)
            SEL_A:   hit_o = listen_i & rise_i;
            SEL_B:   hit_o = listen_i & fall_i;
            SEL_C:   hit_o = listen_i & (rise_i | fall_i);
            default: hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_val_o <= '0;
            flag_o    <= 1'b0;
        end else if (hit_o) begin
            cap_val_o <= cnt_i;
            flag_o    <= 1'b1;
        end else if (flag_clr_i) begin
            flag_o    <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_mode_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             tog_ovf_i,
    input  logic             max_duty_i,
    input  logic             ovf_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    output logic             listen_o,
    output logic             pin_o,
    output logic             pin_oe_o
);
    ch_state_t state_q, state_d;
    logic      forced_q;
    logic      match;
    logic      pwm_clr;

    assign match   = (cnt_i == cmp_val_i);
    assign pwm_clr = ~cap_mode_i & tog_ovf_i & (edge_sel_i == SEL_B);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // forced-duty request, sampled only on period boundaries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     forced_q <= 1'b0;
        else if (ovf_i) forced_q <= max_duty_i;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (edge_sel_i == SEL_NONE) begin
            state_d = ST_OFF;
        end else if (cap_mode_i) begin
            state_d = ST_CAP;
        end else begin
            unique case (state_q)
                ST_OFF, ST_CAP: state_d = ST_LOW;
                ST_LOW, ST_HIGH: begin
                    if (tog_ovf_i && ovf_i) begin
                        state_d = (state_q == ST_LOW) ? ST_HIGH : ST_LOW;
                    end else if (match) begin
                        unique case (edge_sel_i)
                            SEL_A:   state_d = (state_q == ST_LOW) ? ST_HIGH : ST_LOW;
                            SEL_B:   state_d = ST_LOW;
                            default: state_d = ST_HIGH;
                        endcase
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        listen_o = 1'b0;
        pin_oe_o = 1'b0;
        pin_o    = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_CAP:  listen_o = 1'b1;
            ST_LOW: begin
                pin_oe_o = 1'b1;
                pin_o    = pwm_clr & forced_q;
            end
            ST_HIGH: begin
                pin_oe_o = 1'b1;
                pin_o    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    input  logic             cap_mode_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             tog_ovf_i,
    input  logic             max_duty_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             pin_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             flag_o,
    output logic             pin_o,
    output logic             pin_oe_o
);
    logic rise, fall, listen, cap_hit;

    tmr_chan_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    tmr_chan_capture #(.CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .listen_i   (listen),
        .edge_sel_i (edge_sel_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .cnt_i      (cnt_i),
        .flag_clr_i (flag_clr_i),
        .hit_o      (cap_hit),
        .cap_val_o  (cap_val_o),
        .flag_o     (flag_o)
    );

    tmr_chan_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_mode_i (cap_mode_i),
        .edge_sel_i (edge_sel_i),
        .tog_ovf_i  (tog_ovf_i),
        .max_duty_i (max_duty_i),
        .ovf_i      (ovf_i),
        .cnt_i      (cnt_i),
        .cmp_val_i  (cmp_val_i),
        .listen_o   (listen),
        .pin_o      (pin_o),
        .pin_oe_o   (pin_oe_o)
    );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_mode_i,
    input logic [1:0]       edge_sel_i,
    input logic             tog_ovf_i,
    input logic             max_duty_i,
    input logic             ovf_i,
    input logic             flag_clr_i,
    input logic             cap_hit,
    input logic [CNT_W-1:0] cap_val_o,
    input logic             flag_o,
    input logic             pin_o,
    input logic             pin_oe_o
);
    a_r2_released: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == 2'b00) |=> (!pin_oe_o && !pin_o));

    a_r3_capture_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |-> !pin_oe_o);

    a_r4_value_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val_o) |-> flag_o);

    a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !cap_hit) |=> !flag_o);

    a_r6_ovf_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o && !cap_mode_i && tog_ovf_i && ovf_i && edge_sel_i != 2'b10)
        |=> (!pin_oe_o || edge_sel_i == 2'b10 || pin_o != $past(pin_o)));

    a_r8_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o && !cap_mode_i && tog_ovf_i && edge_sel_i == 2'b10 && max_duty_i && ovf_i)
        |=> (!pin_oe_o || cap_mode_i || !tog_ovf_i || edge_sel_i != 2'b10 || pin_o));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_mode_i (cap_mode_i),
    .edge_sel_i (edge_sel_i),
    .tog_ovf_i  (tog_ovf_i),
    .max_duty_i (max_duty_i),
    .ovf_i      (ovf_i),
    .flag_clr_i (flag_clr_i),
    .cap_hit    (cap_hit),
    .cap_val_o  (cap_val_o),
    .flag_o     (flag_o),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
);

// File: tb/test_tmr_chan.sv
module test_tmr_chan;
    localparam int CNT_W = 8;
    localparam int PER   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_i = '0;
    logic             ovf_i = 1'b0;
    logic             cap_mode_i = 1'b0;
    logic [1:0]       edge_sel_i = 2'b00;
    logic             tog_ovf_i = 1'b0;
    logic             max_duty_i = 1'b0;
    logic [CNT_W-1:0] cmp_val_i = '0;
    logic             pin_i = 1'b0;
    logic             flag_clr_i = 1'b0;
    logic [CNT_W-1:0] cap_val_o;
    logic             flag_o, pin_o, pin_oe_o;

    int    n_vec = 0;
    int    n_bad = 0;
    int    ct = 0;
    string req = "R1";

    always #4 clk = ~clk;

    tmr_chan #(.CNT_W(CNT_W)) i_tmr_chan (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .ovf_i(ovf_i),
        .cap_mode_i(cap_mode_i), .edge_sel_i(edge_sel_i), .tog_ovf_i(tog_ovf_i),
        .max_duty_i(max_duty_i), .cmp_val_i(cmp_val_i), .pin_i(pin_i),
        .flag_clr_i(flag_clr_i), .cap_val_o(cap_val_o), .flag_o(flag_o),
        .pin_o(pin_o), .pin_oe_o(pin_oe_o)
    );

    // behavioural reference
    bit p1 = 0, p2 = 0, p3 = 0;
    bit listening = 0, driving = 0, level = 0, force_req = 0, m_flag = 0;
    logic [CNT_W-1:0] m_cap = '0;

    always @(posedge clk) begin
        bit up, down, got;
        if (!rst_n) begin
            p1 = 0; p2 = 0; p3 = 0; listening = 0; driving = 0;
            level = 0; force_req = 0; m_flag = 0; m_cap = '0;
        end else begin
            up   = p2 && !p3;
            down = !p2 && p3;
            got  = listening && ((edge_sel_i == 1 && up) || (edge_sel_i == 2 && down) ||
                                 (edge_sel_i == 3 && (up || down)));
            if (got) begin m_flag = 1; m_cap = cnt_i; end
            else if (flag_clr_i) m_flag = 0;
            if (edge_sel_i == 0 || cap_mode_i) begin driving = 0; level = 0; end
            else if (!driving) begin driving = 1; level = 0; end
            else if (tog_ovf_i && ovf_i) level = !level;
            else if (cnt_i == cmp_val_i) begin
                if (edge_sel_i == 1) level = !level;
                else level = (edge_sel_i == 3);
            end
            listening = cap_mode_i && edge_sel_i != 0;
            if (ovf_i) force_req = max_duty_i;
            p3 = p2; p2 = p1; p1 = pin_i;
        end
    end

    task automatic check();
        bit exp_oe, exp_pin;
        exp_oe  = driving;
        exp_pin = driving && ((!cap_mode_i && tog_ovf_i && edge_sel_i == 2 && force_req) ? 1'b1 : level);
        n_vec++;
        if (pin_oe_o !== exp_oe || pin_o !== exp_pin || flag_o !== m_flag || cap_val_o !== m_cap) begin
            n_bad++;
            $display("FAIL %s t=%0t oe/pin/flag/cap actual %b/%b/%b/%0d expected %b/%b/%b/%0d",
                     req, $time, pin_oe_o, pin_o, flag_o, cap_val_o, exp_oe, exp_pin, m_flag, m_cap);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check();
            cnt_i      = CNT_W'(ct);
            ovf_i      = (ct == PER - 1);
            ct         = (ct + 1) % PER;
            flag_clr_i = 1'b0;
        end
    endtask

    task automatic cfg(input bit cm, input bit [1:0] es, input bit tg, input int cmpv);
        cap_mode_i = cm; edge_sel_i = es; tog_ovf_i = tg; cmp_val_i = CNT_W'(cmpv);
    endtask

    task automatic wiggle(input int k);
        for (int i = 0; i < k; i++) begin
            pin_i = ~pin_i;
            cyc(4 + i % 5);
        end
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, then first cycles after release
        req = "R1"; pin_i = 1'b1;
        cyc(5);
        rst_n = 1'b1;
        cyc(4);
        pin_i = 1'b0;
        // R5: compare actions toggle, clear, set
        req = "R5"; cfg(0, 2'b01, 0, 5);  cyc(3 * PER);
        cfg(0, 2'b11, 0, 9);  cyc(2 * PER);
        cfg(0, 2'b10, 0, 12); cyc(2 * PER);
        // R6: overflow toggling on/off
        req = "R6"; cfg(0, 2'b11, 1, 7); cyc(3 * PER);
        cfg(0, 2'b01, 1, 3); cyc(3 * PER);
        cfg(0, 2'b01, 0, 3); cyc(2 * PER);
        // R7: compare coincides with overflow
        req = "R7"; cfg(0, 2'b10, 1, PER - 1); cyc(3 * PER);
        cfg(0, 2'b11, 1, PER - 1); cyc(3 * PER);
        // R8: forced duty set and cleared mid-period
        req = "R8"; cfg(0, 2'b10, 1, 6); cyc(2 * PER + 3);
        max_duty_i = 1'b1; cyc(3 * PER);
        max_duty_i = 1'b0; cyc(3 * PER);
        max_duty_i = 1'b1; cyc(PER - 3);
        // R9: forcing has no effect in other configurations
        req = "R9"; cfg(0, 2'b11, 1, 6); cyc(3 * PER);
        cfg(0, 2'b01, 0, 6); cyc(2 * PER);
        max_duty_i = 1'b0;
        // R2: release from compare use
        req = "R2"; cfg(0, 2'b00, 1, 6); wiggle(4);
        // R3: rising, falling and both edges captured
        req = "R3"; cfg(1, 2'b01, 1, 6); cyc(3);
        flag_clr_i = 1'b1; cyc(1);
        wiggle(8);
        cfg(1, 2'b10, 0, 6); wiggle(8);
        cfg(1, 2'b11, 0, 6); wiggle(8);
        // R4: flag clear, hold, and clear racing a capture
        req = "R4"; flag_clr_i = 1'b1; cyc(6);
        pin_i = ~pin_i; cyc(2);
        flag_clr_i = 1'b1; cyc(3);
        flag_clr_i = 1'b1; cyc(5);
        // R6: overflow toggle ignored in capture use
        req = "R6"; cfg(1, 2'b01, 1, 6); cyc(2 * PER);
        // R2: release from capture use, pin edges ignored
        req = "R2"; cfg(1, 2'b00, 0, 6); wiggle(6);
        // R1: reset clears everything mid-run
        req = "R1"; cfg(0, 2'b10, 1, 6); max_duty_i = 1'b1; cyc(2 * PER);
        rst_n = 1'b0; cyc(3);
        cfg(0, 2'b00, 0, 0); max_duty_i = 1'b0; rst_n = 1'b1; cyc(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule